// File: doc/BRIEF.md
# Double-Width Funnel Shifter

This block is a purely combinational 64-bit shift datapath that serves two operations, a left double shift and a right double shift. Each takes a source word, a shift-amount word and a fill word. The source is rotated by the requested distance. A generated mask then picks which bit positions keep rotated source bits and which take bits from the fill word. The bits that leave the 64-bit window are returned as a separate spill word. A flag reports whether any of them was a one.

Because the spill word and the fill input are both available, software can chain shifts across the limbs of a multi-word integer. The spill of one limb becomes the fill of the next. When a record request is present, the block also produces a 4-bit condition code that classifies the result and carries a copy of a sticky summary-overflow bit.

Top module: `fsh_unit`

## Requirements
- R1: The shift distance n is taken from the low 6 bits of `amt_i` (0 to 63). Bits 63 down to 6 of `amt_i` have no effect on any output.
- R2: With `dir_i` = 0 (left), `res_o` equals `src_i` shifted left by n, with its low n bits taken from the low n bits of `fill_i`.
- R3: With `dir_i` = 1 (right), `res_o` equals `src_i` logically shifted right by n, with its top n bits taken from the top n bits of `fill_i`.
- R4: `spill_o` holds exactly the source bits that left the window, at their rotated positions. For a left shift these are the top n source bits, placed in bits n-1..0. For a right shift these are the low n source bits, placed in bits 63..64-n. Every other bit of `spill_o` is zero.
- R5: `ovf_o` is 1 exactly when `spill_o` is nonzero.
- R6: When n is 0, in either direction, `res_o` equals `src_i`, `spill_o` is zero and `ovf_o` is 0.
- R7: When `rec_i` = 1, `cc_vld_o` is 1 and `cc_o` = {lt, gt, eq, so}, MSB first. Here lt = `res_o[63]`, gt = result nonzero with bit 63 clear, eq = result zero, and so = `so_i`. Exactly one of lt, gt and eq is set.
- R8: When `rec_i` = 0, `cc_vld_o` is 0 and `cc_o` is 4'b0000, whatever `so_i` and the result are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_i | input | 1 | Shift direction: 0 left, 1 right |
| rec_i | input | 1 | Record request; enables the condition code |
| src_i | input | 64 | Word to be shifted |
| amt_i | input | 64 | Shift amount word; only bits 5..0 are used |
| fill_i | input | 64 | Word supplying the vacated bit positions |
| so_i | input | 1 | Summary-overflow bit copied into the condition code |
| res_o | output | 64 | Merged shift result |
| spill_o | output | 64 | Bits shifted out of the window |
| ovf_o | output | 1 | Spill word is nonzero |
| cc_o | output | 4 | Condition code {lt, gt, eq, so} |
| cc_vld_o | output | 1 | Condition code valid |

## Verification
The embedded assertions are evaluated whenever the inputs change. They cover bit conservation between the kept field and the spill word, the zero-distance pass-through, the link between overflow and a nonzero distance, the gating of the condition code by the record bit, and the single-relation property of the condition code. Only the bench's scenarios can show the exact bit placement of the result and the spill word for every distance in both directions, and that the upper amount bits are ignored. For this the bench compares against a 128-bit shift model over random operands and all 64 distances.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  localparam int FSH_W  = 64;
  localparam int FSH_AW = $clog2(FSH_W);

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } fsh_dir_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } fsh_cc_t;
endpackage

// File: rtl/fsh_rotl.sv
module fsh_rotl #(
  parameter int W  = 64,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din_i,
  input  logic [AW-1:0] rot_i,
  output logic [W-1:0]  dout_o
);
  logic [W-1:0] stage [0:AW];

  assign stage[0] = din_i;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stage[k+1] = rot_i[k] ? {stage[k][W-1-SH:0], stage[k][W-1:W-SH]}
                                 : stage[k];
  end

  assign dout_o = stage[AW];
endmodule

// File: rtl/fsh_mask.sv
module fsh_mask #(
  parameter int W  = 64,
  parameter int AW = $clog2(W)
) (
  input  logic [AW-1:0] n_i,
  input  logic          dir_i,
  output logic [W-1:0]  keep_o
);
  logic [W-1:0] low_n;
  logic [W-1:0] high_n;

  assign low_n = ~({W{1'b1}} << n_i);

  for (genvar b = 0; b < W; b++) begin : g_rev
    assign high_n[b] = low_n[W-1-b];
  end

  assign keep_o = dir_i ? ~high_n : ~low_n;
endmodule

// File: rtl/fsh_cond.sv
module fsh_cond
  import fsh_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] res_i,
  input  logic         rec_i,
  input  logic         so_i,
  output fsh_cc_t      cc_o,
  output logic         vld_o
);
  logic is_zero;

  assign is_zero = ~|res_i;

  always_comb begin
    cc_o  = '0;
    vld_o = 1'b0;
    if (rec_i) begin
      vld_o   = 1'b1;
      cc_o.lt = res_i[W-1];
      cc_o.gt = ~res_i[W-1] & ~is_zero;
      cc_o.eq = is_zero;
      cc_o.so = so_i;
    end
  end

  always_comb begin
    if (rec_i) begin
      a_r7_one_relation: assert ($countones({cc_o.lt, cc_o.gt, cc_o.eq}) == 1)
        else $error("R7: condition code not a single relation");
    end else begin
      a_r8_no_record: assert (!vld_o && cc_o == '0)
        else $error("R8: condition code active without record");
    end
  end
endmodule

// File: rtl/fsh_unit.sv
module fsh_unit
  import fsh_pkg::*;
#(
  parameter int W  = FSH_W,
  localparam int AW = $clog2(W)
) (
  input  logic         dir_i,
  input  logic         rec_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] amt_i,
  input  logic [W-1:0] fill_i,
  input  logic         so_i,
  output logic [W-1:0] res_o,
  output logic [W-1:0] spill_o,
  output logic         ovf_o,
  output logic [3:0]   cc_o,
  output logic         cc_vld_o
);
  logic [AW-1:0] n;
  logic [AW-1:0] rot_amt;
  logic [W-1:0]  rotated;
  logic [W-1:0]  keep;
  logic [W-1:0]  kept;
  fsh_cc_t       cc;

  assign n       = amt_i[AW-1:0];
  assign rot_amt = (dir_i == DIR_RIGHT) ? (~n + 1'b1) : n;

  fsh_rotl #(.W(W), .AW(AW)) u_rotl (
    .din_i  (src_i),
    .rot_i  (rot_amt),
    .dout_o (rotated)
  );

  fsh_mask #(.W(W), .AW(AW)) u_mask (
    .n_i    (n),
    .dir_i  (dir_i),
    .keep_o (keep)
  );

  assign kept    = rotated & keep;
  assign res_o   = kept | (fill_i & ~keep);
  assign spill_o = rotated & ~keep;
  assign ovf_o   = |spill_o;

  fsh_cond #(.W(W)) u_cond (
    .res_i (res_o),
    .rec_i (rec_i),
    .so_i  (so_i),
    .cc_o  (cc),
    .vld_o (cc_vld_o)
  );

  assign cc_o = cc;

  always_comb begin
    a_r4_bits_conserved: assert ($countones(kept) + $countones(spill_o) == $countones(src_i))
      else $error("R4: kept and spilled bits do not account for the source");
    if (n == '0) begin
      a_r6_zero_distance: assert (res_o == src_i && spill_o == '0 && !ovf_o)
        else $error("R6: zero distance altered the source");
    end
    if (ovf_o) begin
      a_r5_ovf_needs_shift: assert (n != '0)
        else $error("R5: overflow flagged with zero distance");
    end
  end
endmodule

// File: tb/tb_fsh_unit.sv
module tb_fsh_unit;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         dir_i, rec_i, so_i;
  logic [W-1:0] src_i, amt_i, fill_i;
  logic [W-1:0] res_o, spill_o;
  logic         ovf_o, cc_vld_o;
  logic [3:0]   cc_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  fsh_unit dut (
    .dir_i(dir_i), .rec_i(rec_i), .src_i(src_i), .amt_i(amt_i),
    .fill_i(fill_i), .so_i(so_i), .res_o(res_o), .spill_o(spill_o),
    .ovf_o(ovf_o), .cc_o(cc_o), .cc_vld_o(cc_vld_o)
  );

  function automatic logic [W-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic apply(input logic d, input logic r, input logic [W-1:0] a,
                       input logic [W-1:0] amt, input logic [W-1:0] f, input logic s);
    @(negedge clk);
    dir_i = d; rec_i = r; src_i = a; amt_i = amt; fill_i = f; so_i = s;
    @(posedge clk);
    #1;
  endtask

  task automatic model(input logic d, input logic [W-1:0] a, input logic [W-1:0] f,
                       input int n, output logic [W-1:0] r, output logic [W-1:0] sp);
    logic [2*W-1:0] t;
    logic [W-1:0]   low;
    low = (n == 0) ? '0 : ({W{1'b1}} >> (W - n));
    if (!d) begin
      t  = {{W{1'b0}}, a} << n;
      r  = t[W-1:0] | (f & low);
      sp = t[2*W-1:W];
    end else begin
      t  = {a, {W{1'b0}}} >> n;
      r  = t[2*W-1:W] | (f & ~({W{1'b1}} >> n));
      sp = t[W-1:0];
    end
  endtask

  task automatic t_idle;
    apply(1'b0, 1'b0, '0, '0, '0, 1'b0);
    chk("R8 idle cc_vld", {63'b0, cc_vld_o}, '0);
    chk("R6 idle res", res_o, '0);
    chk("R5 idle ovf", {63'b0, ovf_o}, '0);
  endtask

  task automatic t_zero_shift;
    for (int d = 0; d < 2; d++) begin
      logic [W-1:0] a = rnd64();
      apply(d[0], 1'b0, a, {rnd64()} & ~64'h3f, rnd64(), 1'b0);
      chk("R6 zero-shift res", res_o, a);
      chk("R6 zero-shift spill", spill_o, '0);
      chk("R6 zero-shift ovf", {63'b0, ovf_o}, '0);
    end
  endtask

  task automatic t_sweep(input logic d);
    for (int n = 0; n < 64; n++) begin
      logic [W-1:0] a = rnd64();
      logic [W-1:0] f = rnd64();
      logic [W-1:0] er, es;
      model(d, a, f, n, er, es);
      apply(d, 1'b0, a, W'(n), f, 1'b0);
      chk(d ? "R3 right res" : "R2 left res", res_o, er);
      chk("R4 spill", spill_o, es);
      chk("R5 ovf", {63'b0, ovf_o}, {63'b0, |es});
    end
  endtask

  task automatic t_upper_ignored;
    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] a = rnd64();
      logic [W-1:0] f = rnd64();
      logic [W-1:0] er, es;
      int n = $urandom_range(0, 63);
      logic d = i[0];
      model(d, a, f, n, er, es);
      apply(d, 1'b1, a, (rnd64() & ~64'h3f) | W'(n), f, 1'b0);
      chk("R1 upper amount res", res_o, er);
      chk("R1 upper amount spill", spill_o, es);
    end
  endtask

  task automatic t_cond;
    apply(1'b0, 1'b1, 64'h8000_0000_0000_0001, 64'd0, '0, 1'b1);
    chk("R7 negative cc", {60'b0, cc_o}, {60'b0, 4'b1001});
    chk("R7 cc_vld", {63'b0, cc_vld_o}, 64'd1);
    apply(1'b1, 1'b1, 64'h0000_0000_0000_00f0, 64'd4, '0, 1'b0);
    chk("R7 positive cc", {60'b0, cc_o}, {60'b0, 4'b0100});
    apply(1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'd1, '0, 1'b1);
    chk("R7 zero cc", {60'b0, cc_o}, {60'b0, 4'b0011});
    chk("R5 zero result still overflows", {63'b0, ovf_o}, 64'd1);
    apply(1'b1, 1'b1, 64'h1, 64'd1, 64'hffff_ffff_ffff_ffff, 1'b0);
    chk("R3 fill top bit", res_o, 64'h8000_0000_0000_0000);
    chk("R7 fill sign cc", {60'b0, cc_o}, {60'b0, 4'b1000});
  endtask

  task automatic t_no_record;
    apply(1'b0, 1'b0, 64'h8000_0000_0000_0000, 64'd0, '0, 1'b1);
    chk("R8 no record cc", {60'b0, cc_o}, '0);
    chk("R8 no record vld", {63'b0, cc_vld_o}, '0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    t_idle();
    t_zero_shift();
    t_sweep(1'b0);
    t_sweep(1'b1);
    t_upper_ignored();
    t_cond();
    t_no_record();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule